// File: doc/BRIEF.md
# Interframe Gap Scheduler with Pseudo-Random Jitter

This block sets the spacing of a burst of repeated transmission frames. A send strobe opens the burst and starts the first frame at once. The block then waits for the transmitter to report the end of each frame. Before the next frame starts, it waits out a gap measured in ticks of an external one-millisecond strobe.

The gap length is a programmable base time plus a random extension. The extension is the current value of a 7-bit Fibonacci LFSR with polynomial x^7+x^6+1, which advances once per finished frame. The LFSR seed and the base time are captured when the burst starts. An all-zero seed locks the LFSR at zero, so the spacing is fixed. A base time of zero sends the frames back to back with no gap. The illegal base times 1 to 4 are raised to 5.

The frame count sets how many frames the burst carries. When the last frame ends, the busy flag drops.

Top module: `frame_gap_sched`

## Requirements
- R1: After reset, busy_o is 0, frame_start_o is 0 and lfsr_o is 0x00. The internal base time resets to 0x80.
- R2: A send_i while idle has the following effects in the next cycle: frame_start_o pulses for one cycle, busy_o goes to 1 and lfsr_o shows seed_i.
- R3: Each frame_done_i taken while a frame is in flight advances the LFSR once, as new = {old[5:0], old[6]^old[5]}. Zero stays zero. A nonzero seed returns to its own value after exactly 127 steps. At all other times, lfsr_o holds its value.
- R4: With a nonzero base time, the gap after a frame lasts base + lfsr ticks. Here lfsr is the value shown on lfsr_o after the step. The tick sampled on the frame_done_i cycle is not counted. frame_start_o pulses in the cycle after the tick that completes the gap.
- R5: A captured base time of 1 to 4 acts as 5. Zero and values from 5 to 255 are used unchanged.
- R6: With base time 0, the next frame_start_o pulses in the cycle right after frame_done_i. Ticks and the LFSR value do not change this timing, and the LFSR still steps.
- R7: A burst carries frame_cnt_i frames, and a count of 0 gives one frame. busy_o falls in the cycle after the last frame_done_i, and no further frame_start_o follows.
- R8: Two inputs are ignored: send_i while busy, and frame_done_i while idle or during a gap. They change neither the LFSR nor the frame timing.
- R9: base_time_i, seed_i and frame_cnt_i are sampled only at the accepted send_i. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-millisecond tick strobe |
| base_time_i | input | 8 | Base gap in ms (0 or 5..255) |
| seed_i | input | 7 | LFSR seed |
| send_i | input | 1 | Start-of-burst strobe |
| frame_cnt_i | input | 8 | Frames per burst (0 means 1) |
| frame_done_i | input | 1 | Transmitter finished the current frame |
| frame_start_o | output | 1 | One-cycle pulse starting a frame |
| busy_o | output | 1 | Burst in progress |
| lfsr_o | output | 7 | Current LFSR state |

## Verification
Four kinds of burst are run against a cycle-by-cycle reference model, and each one separates a different class of fault:
- A legal base time with a nonzero seed shows whether the random term is added after the step rather than before it.
- A base time of 2 with a zero seed separates the clamp from a pass-through, and also separates LFSR lock-up from stepping.
- A zero base time with seed 1 over 128 frames exposes wrong taps, which show up as a period other than 127, and any gap inserted where none belongs.
- A count of 0 and a count of 1 separate off-by-one errors in the frame count.

Inside a running burst, the bench injects a stray send with new settings and a stray frame-done during a gap. These confirm that the captured settings and the LFSR are left alone.

// File: rtl/fgs_pkg.sv
package fgs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GAP   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fgs_lfsr.sv
module fgs_lfsr #(
  parameter int W   = 7,
  parameter int TAP = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] state_o,
  output logic [W-1:0] next_o
);
  logic [W-1:0] q;
  logic         fb;

  assign fb      = q[W-1] ^ q[TAP-1];
  assign next_o  = {q[W-2:0], fb};
  assign state_o = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= seed_i;
    else if (step_i) q <= next_o;
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q != '0 && !load_i) |=> (q != '0)); // R3
  AST_LFSR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(q)); // R3
endmodule

// File: rtl/fgs_base_clamp.sv
module fgs_base_clamp #(
  parameter int W   = 8,
  parameter int MIN = 5
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] legal_o
);
  localparam logic [W-1:0] MinVal = W'(MIN);

  always_comb begin
    legal_o = raw_i;
    if (raw_i != '0 && raw_i < MinVal) legal_o = MinVal;
  end
endmodule

// File: rtl/fgs_gap_counter.sv
module fgs_gap_counter #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == W'(1)) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  AST_GAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/frame_gap_sched.sv
module frame_gap_sched #(
  parameter int          BASE_W   = 8,
  parameter int          LFSR_W   = 7,
  parameter int          LFSR_TAP = 6,
  parameter int          CNT_W    = 8,
  parameter int          MIN_BASE = 5,
  parameter logic [7:0]  BASE_RST = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_ms_i,
  input  logic [BASE_W-1:0] base_time_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              send_i,
  input  logic [CNT_W-1:0]  frame_cnt_i,
  input  logic              frame_done_i,
  output logic              frame_start_o,
  output logic              busy_o,
  output logic [LFSR_W-1:0] lfsr_o
);
  import fgs_pkg::*;

  localparam int GAP_W = ((BASE_W > LFSR_W) ? BASE_W : LFSR_W) + 1;

  seq_state_e        state_q;
  logic [BASE_W-1:0] base_q, base_legal;
  logic [CNT_W-1:0]  left_q;
  logic              start_q;
  logic [LFSR_W-1:0] lfsr_next;
  logic              accept, fin, gap_load, expire;
  logic [GAP_W-1:0]  gap_val;

  assign accept   = (state_q == ST_IDLE) && send_i;
  assign fin      = (state_q == ST_FRAME) && frame_done_i;
  assign gap_load = fin && (left_q != '0) && (base_q != '0);
  assign gap_val  = GAP_W'(base_q) + GAP_W'(lfsr_next);

  fgs_base_clamp #(.W(BASE_W), .MIN(MIN_BASE)) u_clamp (
    .raw_i  (base_time_i),
    .legal_o(base_legal)
  );

  fgs_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .seed_i (seed_i),
    .step_i (fin),
    .state_o(lfsr_o),
    .next_o (lfsr_next)
  );

  fgs_gap_counter #(.W(GAP_W)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (gap_load),
    .load_val_i(gap_val),
    .tick_i    (tick_ms_i && (state_q == ST_GAP)),
    .expire_o  (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= BASE_W'(BASE_RST);
      left_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (send_i) begin
          base_q  <= base_legal;
          left_q  <= (frame_cnt_i == '0) ? '0 : frame_cnt_i - CNT_W'(1);
          start_q <= 1'b1;
          state_q <= ST_FRAME;
        end
        ST_FRAME: if (frame_done_i) begin
          if (left_q == '0) state_q <= ST_IDLE;
          else if (base_q == '0) begin
            start_q <= 1'b1;
            left_q  <= left_q - CNT_W'(1);
          end else state_q <= ST_GAP;
        end
        ST_GAP: if (expire) begin
          start_q <= 1'b1;
          left_q  <= left_q - CNT_W'(1);
          state_q <= ST_FRAME;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign frame_start_o = start_q;
  assign busy_o        = (state_q != ST_IDLE);

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> busy_o); // R7
  AST_GAP_WAITS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP && !tick_ms_i) |=> !frame_start_o); // R4
  AST_SEND_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && send_i && !frame_done_i) |=> busy_o); // R8
  AST_BASE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (base_q == '0 || base_q >= BASE_W'(MIN_BASE))); // R5
  AST_BASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(base_q)); // R9
endmodule

// File: tb/sim_frame_gap_sched.sv
`timescale 1ns/1ps
module sim_frame_gap_sched;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_ms_i = 1'b0;
  logic [7:0] base_time_i = 8'd0;
  logic [6:0] seed_i = 7'd0;
  logic       send_i = 1'b0;
  logic [7:0] frame_cnt_i = 8'd0;
  logic       frame_done_i = 1'b0;
  logic       frame_start_o, busy_o;
  logic [6:0] lfsr_o;

  int total = 0, bad = 0;
  bit done_flag = 0, tick_en = 1, cmp_en = 0;
  int tdiv = 0, mticks = 0, nstarts = 0;
  int mst = 0, mleft = 0, mbase = 128, mlf = 0, mgap = 0, mstart = 0;

  always #2.5 clk_i = ~clk_i;

  frame_gap_sched u0 (.*);

  function automatic int lstep(int v);
    return ((v << 1) & 127) | (((v >> 6) ^ (v >> 5)) & 1);
  endfunction
  function automatic int clampb(int b);
    return (b >= 1 && b <= 4) ? 5 : b;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (tick_en) begin tick_ms_i = (tdiv == 3); tdiv = (tdiv + 1) % 4; end
    else tick_ms_i = 1'b0;
  end

  // behavioural reference
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mst = 0; mleft = 0; mbase = 128; mlf = 0; mgap = 0; mstart = 0;
    end else begin
      mstart = 0;
      if (mst == 0) begin
        if (send_i) begin
          mbase = clampb(base_time_i); mleft = (frame_cnt_i == 0) ? 0 : frame_cnt_i - 1;
          mlf = seed_i; mstart = 1; mst = 1;
        end
      end else if (mst == 1) begin
        if (frame_done_i) begin
          mlf = lstep(mlf);
          if (mleft == 0) mst = 0;
          else if (mbase == 0) begin mstart = 1; mleft--; end
          else begin mgap = mbase + mlf; mst = 2; end
        end
      end else if (tick_ms_i) begin
        mgap--;
        if (mgap == 0) begin mstart = 1; mleft--; mst = 1; end
      end
    end
  end

  always @(posedge clk_i) begin
    if (frame_done_i) mticks <= 0;
    else if (tick_ms_i) mticks <= mticks + 1;
  end

  always @(negedge clk_i) if (cmp_en) begin
    if (frame_start_o) nstarts++;
    chk(frame_start_o == mstart[0], "R4 model frame_start", frame_start_o, mstart);
    chk(busy_o == (mst != 0), "R7 model busy", busy_o, mst != 0);
    chk(lfsr_o == mlf[6:0], "R3 model lfsr", lfsr_o, mlf);
  end

  // mode 1: stray send with new settings during first gap; mode 2: stray done during gap
  task automatic burst(int b, int s, int c, int mode, output int period);
    int beff, lf, nfr, waited, n0;
    beff = clampb(b); lf = s; nfr = (c == 0) ? 1 : c; period = 0; n0 = nstarts;
    base_time_i = 8'(b); seed_i = 7'(s); frame_cnt_i = 8'(c); send_i = 1;
    @(negedge clk_i); send_i = 0;
    chk(frame_start_o && busy_o, "R2 start after send", {frame_start_o, busy_o}, 3);
    chk(lfsr_o == 7'(s), "R2 seed loaded", lfsr_o, s);
    for (int i = 0; i < nfr; i++) begin
      bit skip = 0;
      if (i == 1 && mode == 1) begin
        send_i = 1; seed_i = 7'h7f; base_time_i = 8'd9; frame_cnt_i = 8'd1;
        @(negedge clk_i); send_i = 0;
        chk(lfsr_o == 7'(lf) && busy_o, "R8 send ignored while busy", lfsr_o, lf);
      end
      if (i == 1 && mode == 2) begin
        frame_done_i = 1; @(negedge clk_i); frame_done_i = 0; skip = 1;
        chk(lfsr_o == 7'(lf) && !frame_start_o, "R8 done ignored in gap", lfsr_o, lf);
      end
      waited = 0;
      while (!frame_start_o) begin @(negedge clk_i); waited++; end
      if (i > 0 && beff == 0)
        chk(waited == 0, "R6 back to back", waited, 0);
      else if (i > 0 && !skip)
        chk(mticks == beff + lf, "R4 R5 R9 gap ticks", mticks, beff + lf);
      @(negedge clk_i); frame_done_i = 1;
      @(negedge clk_i); frame_done_i = 0; lf = lstep(lf);
      chk(lfsr_o == 7'(lf), "R3 lfsr step", lfsr_o, lf);
      if (period == 0 && lfsr_o == 7'(s)) period = i + 1;
    end
    chk(!busy_o, "R7 busy drops", busy_o, 0);
    repeat (8) @(negedge clk_i);
    chk(nstarts - n0 == nfr, "R7 frame count", nstarts - n0, nfr);
  endtask

  initial begin
    int p;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !frame_start_o && lfsr_o == 0, "R1 reset state", lfsr_o, 0);
    rst_ni = 1; cmp_en = 1;
    @(negedge clk_i);
    burst(5, 7'h15, 3, 0, p);
    burst(2, 0, 2, 0, p);
    chk(lfsr_o == 0, "R3 zero seed locks", lfsr_o, 0);
    burst(0, 1, 128, 0, p);
    chk(p == 127, "R3 period", p, 127);
    burst(9, 7'h40, 0, 0, p);
    burst(7, 7'h33, 1, 0, p);
    burst(6, 7'h2a, 3, 1, p);
    burst(4, 7'h11, 3, 2, p);
    frame_done_i = 1; @(negedge clk_i); frame_done_i = 0;
    chk(!busy_o && !frame_start_o && lfsr_o == 7'(lstep(lstep(lstep(7'h11)))) ,
        "R8 done ignored idle", lfsr_o, lstep(lstep(lstep(7'h11))));
    tick_en = 0;
    burst(0, 7'h05, 2, 0, p);
    tick_en = 1;
    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done_flag) begin
      done_flag = 1; total++; bad++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule